// File: doc/BRIEF.md
# Data Bus Line Test Sequencer

This block exercises the data lines of a 64-bit memory bus to find lines that are shorted together, open, or left floating. After a start pulse it walks through a set of twelve bit-group patterns. Each pattern goes through the same three memory operations:

- The pattern is written to a chosen target word.
- A fixed disturbing constant is written to the word that follows the target.
- The target word is read back once and compared against the pattern.

The disturbing write drives the bus to a different state just before the readback. Because of that, a floating line cannot simply hold the value that was last written to it.

The block drives a single request/acknowledge memory port and never has more than one request open. A run never stops early. Every pattern is applied even after a mismatch has been seen. The first mismatch is recorded: its pattern index, the expected word and the complete observed word. The observed word is kept whole so that a broken byte lane shows up as bytes of the disturbing constant. Busy, done and fail outputs tell the system where the run stands.

Top module: `dbus_line_test`

## Requirements
- R1: Patterns are applied in index order 0..11. Index k < 6 sets bit i of the word when bit k of i is 1: AAAA…, CCCC…, F0F0…, FF00…, FFFF0000…, FFFFFFFF00000000. Index k >= 6 is the one's complement of pattern 11-k, so index 6 is 00000000FFFFFFFF and index 11 is 5555….
- R2: For each pattern the block issues exactly three memory requests, in this order:
  - a write (memWe=1) of the pattern to targetAddr;
  - a write of 0x0123456789ABCDEF to targetAddr+1;
  - a read (memWe=0) of targetAddr.
  A run therefore makes 36 requests.
- R3: Only one request is outstanding at a time. While memReq is high and memAck is low, memReq, memAddr, memWe and memWdata stay unchanged.
- R4: The target word is read exactly once per pattern, and the value captured with that read's acknowledge is the one that is compared.
- R5: A readback mismatch sets fail, and the run still goes on through all twelve patterns.
- R6: failIdx, failExp and failObs hold the index, the expected word and the full observed word of the first mismatch in a run. Later mismatches do not change them.
- R7: done and fail stay set after a run until the next accepted start. An accepted start clears done, fail, failIdx, failExp and failObs to zero.
- R8: busy rises in the cycle after an accepted start and falls in the cycle done rises. A start seen while busy is ignored, and memReq is low whenever busy is low.
- R9: After reset busy, done, fail and memReq are 0 and the capture outputs are zero.
- R10: If one byte lane returns whatever was last driven on the bus, failObs shows that lane's byte of 0x0123456789ABCDEF, with the other lanes carrying the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when not busy |
| targetAddr | input | ADDR_W | Word address of the target; latched at start |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Request completed; read data valid in this cycle |
| memRdata | input | DATA_W | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, sticky |
| fail | output | 1 | At least one mismatch, sticky |
| failIdx | output | IDX_W | Pattern index of the first mismatch |
| failExp | output | DATA_W | Expected word of the first mismatch |
| failObs | output | DATA_W | Observed word of the first mismatch |

## Verification
The bench covers the following corner cases, and what a wrong design would show in each:

- **Two injected bit flips (patterns 3 and 7).** A design that let later errors overwrite the capture would report index 7 instead of 3. A design that stopped at the first error would leave requests missing from the scoreboard.
- **A floating byte lane.** Only a design that really puts the disturbing write between the pattern write and the readback makes the lane show 0xAB. A design that read back immediately would see no failure.
- **Varying acknowledge latency.** Exposes any design that moves its request before the acknowledge arrives.
- **Start while busy, and sticky outputs.** A start pulse in the middle of a run must not restart it. The sticky outputs must survive idle cycles and clear only on a fresh start.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [1:0] {
    MOP_NONE = 2'd0,
    MOP_PAT  = 2'd1,
    MOP_DIST = 2'd2,
    MOP_READ = 2'd3
  } memOp_t;

  // strobes from control to datapath
  typedef struct packed {
    memOp_t op;       // which memory operation is currently requested
    logic   clrRun;   // new run accepted: clear results, latch target
    logic   capRead;  // readback acknowledged: capture read data
    logic   judge;    // compare captured word against current pattern
    logic   stepIdx;  // advance to next pattern
  } dpCtl_t;

endpackage

// File: rtl/dlt_ctrl.sv
module dlt_ctrl
  import dlt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   memAck,
  input  logic   lastIdx,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   busy,
  output logic   done
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PAT   = 3'd1,
    S_DIST  = 3'd2,
    S_READ  = 3'd3,
    S_JUDGE = 3'd4,
    S_DONE  = 3'd5
  } state_t;

  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    ctl.op      = MOP_NONE;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctl.clrRun = 1'b1;
          stateNxt   = S_PAT;
        end
      end
      S_PAT: begin
        ctl.op = MOP_PAT;
        if (memAck) stateNxt = S_DIST;
      end
      S_DIST: begin
        ctl.op = MOP_DIST;
        if (memAck) stateNxt = S_READ;
      end
      S_READ: begin
        ctl.op      = MOP_READ;
        ctl.capRead = memAck;
        if (memAck) stateNxt = S_JUDGE;
      end
      S_JUDGE: begin
        ctl.judge = 1'b1;
        if (lastIdx) begin
          stateNxt = S_DONE;
        end else begin
          ctl.stepIdx = 1'b1;
          stateNxt    = S_PAT;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign memReq = (state == S_PAT) || (state == S_DIST) || (state == S_READ);
  assign busy   = (state != S_IDLE) && (state != S_DONE);
  assign done   = (state == S_DONE);

endmodule

// File: rtl/dlt_datapath.sv
module dlt_datapath
  import dlt_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter int          ADDR_W  = 16,
  parameter logic [63:0] DISTURB = 64'h0123456789ABCDEF,
  localparam int         LEVELS  = $clog2(DATA_W),
  localparam int         NUM_PAT = 2 * LEVELS,
  localparam int         IDX_W   = $clog2(NUM_PAT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              lastIdx,
  output logic              fail,
  output logic [IDX_W-1:0]  failIdx,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAT - 1);

  // word whose bit i equals bit lvl of i
  function automatic logic [DATA_W-1:0] groupWord(input int lvl);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = ((i >> lvl) & 1) != 0;
    return w;
  endfunction

  logic [DATA_W-1:0] patTab [NUM_PAT];

  for (genvar g = 0; g < NUM_PAT; g++) begin : gPat
    if (g < LEVELS) begin : gBase
      assign patTab[g] = groupWord(g);
    end else begin : gComp
      assign patTab[g] = ~groupWord(NUM_PAT - 1 - g);
    end
  end

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tgtReg;
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] curPat;
  logic              mismatch;

  assign curPat   = patTab[idx];
  assign mismatch = (readWord != curPat);
  assign lastIdx  = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      tgtReg   <= '0;
      readWord <= '0;
      fail     <= 1'b0;
      failIdx  <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else begin
      if (ctl.clrRun) begin
        idx      <= '0;
        tgtReg   <= targetAddr;
        readWord <= '0;
        fail     <= 1'b0;
        failIdx  <= '0;
        failExp  <= '0;
        failObs  <= '0;
      end
      if (ctl.capRead) readWord <= memRdata;
      if (ctl.judge && mismatch) begin
        fail <= 1'b1;
        if (!fail) begin
          failIdx <= idx;
          failExp <= curPat;
          failObs <= readWord;
        end
      end
      if (ctl.stepIdx) idx <= idx + 1'b1;
    end
  end

  always_comb begin
    memAddr  = tgtReg;
    memWe    = 1'b0;
    memWdata = '0;
    case (ctl.op)
      MOP_PAT: begin
        memWe    = 1'b1;
        memWdata = curPat;
      end
      MOP_DIST: begin
        memAddr  = tgtReg + 1'b1;
        memWe    = 1'b1;
        memWdata = DISTURB[DATA_W-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dbus_line_test.sv
module dbus_line_test
  import dlt_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter int          ADDR_W  = 16,
  parameter logic [63:0] DISTURB = 64'h0123456789ABCDEF,
  localparam int         IDX_W   = $clog2(2 * $clog2(DATA_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [IDX_W-1:0]  failIdx,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  dpCtl_t ctl;
  logic   lastIdx;

  dlt_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .memAck  (memAck),
    .lastIdx (lastIdx),
    .ctl     (ctl),
    .memReq  (memReq),
    .busy    (busy),
    .done    (done)
  );

  dlt_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .DISTURB (DISTURB)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .targetAddr (targetAddr),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWe      (memWe),
    .memWdata   (memWdata),
    .lastIdx    (lastIdx),
    .fail       (fail),
    .failIdx    (failIdx),
    .failExp    (failExp),
    .failObs    (failObs)
  );

endmodule

// File: rtl/dbus_line_test_chk.sv
module dbus_line_test_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [IDX_W-1:0]  failIdx,
  input logic [DATA_W-1:0] failObs
);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    fail && !start |=> fail);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && !done && !fail);

  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    fail && !start |=> $stable(failIdx) && $stable(failObs));

endmodule

bind dbus_line_test dbus_line_test_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memAck   (memAck),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .failIdx  (failIdx),
  .failObs  (failObs)
);

// File: tb/sim_dbus_line_test.sv
module sim_dbus_line_test;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 16;
  localparam logic [63:0] DIST = 64'h0123456789ABCDEF;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic              memReq, memWe, memAck;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata;
  logic              busy, done, fail;
  logic [3:0]        failIdx;
  logic [DATA_W-1:0] failExp, failObs;

  always #2 clk = ~clk;

  dbus_line_test #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISTURB(DIST)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .targetAddr(targetAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .busy(busy), .done(done),
    .fail(fail), .failIdx(failIdx), .failExp(failExp), .failObs(failObs)
  );

  // R1: expected pattern table, written out
  logic [63:0] expPat [12] = '{
    64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
    64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
    64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model with fault injection ----------------
  int          faultLane = -1;
  int          flipA = -1, flipB = -1;
  logic [63:0] flipMask = 64'h0000_0000_0001_0000;
  logic [63:0] word0, word1, lastBus;
  int          readCnt = 0;
  int          ackCnt = 0;
  int          waitCnt = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
      waitCnt  <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt >= (ackCnt % 3)) begin
        logic [63:0] rd;
        memAck  <= 1'b1;
        waitCnt <= 0;
        ackCnt  <= ackCnt + 1;
        if (memWe) begin
          if (memAddr == targetAddr) word0 <= memWdata;
          else                       word1 <= memWdata;
          lastBus <= memWdata;
        end else begin
          rd = (memAddr == targetAddr) ? word0 : word1;
          if (readCnt == flipA || readCnt == flipB) rd = rd ^ flipMask;
          if (faultLane >= 0) rd[faultLane*8 +: 8] = lastBus[faultLane*8 +: 8];
          memRdata <= rd;
          readCnt  <= readCnt + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [63:0] data;
  } txn_t;

  txn_t expQ[$];
  int   txSeen = 0;
  logic prevPend = 1'b0;
  txn_t prevTx;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevPend && memReq) begin
        chk(prevTx == {memWe, memAddr, memWdata}, "R3 request held", {memWe, memAddr}, {prevTx.we, prevTx.addr});
      end
      prevPend = memReq && !memAck;
      prevTx   = {memWe, memAddr, memWdata};
      if (memReq && memAck) begin
        txSeen++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected request", {memWe, memAddr}, 0);
        end else begin
          txn_t e;
          e = expQ.pop_front();
          if (e.we)
            chk({memWe, memAddr, memWdata} == e, "R1/R2 write order", memWdata, e.data);
          else
            chk(!memWe && memAddr == e.addr, "R2/R4 read of target", {memWe, memAddr}, {e.we, e.addr});
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic runSeq(input logic [15:0] tgt, input bit pokeMid);
    int n;
    targetAddr = tgt;
    readCnt = 0;
    txSeen = 0;
    for (int k = 0; k < 12; k++) begin
      expQ.push_back('{1'b1, tgt, expPat[k]});
      expQ.push_back('{1'b1, tgt + 16'd1, DIST});
      expQ.push_back('{1'b0, tgt, 64'd0});
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail, "R8/R7 busy after start, flags cleared", {busy, done, fail}, 3'b100);
    chk(failIdx == 0 && failExp == 0 && failObs == 0, "R7 capture cleared", failObs, 0);
    if (pokeMid) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (!done) chk(busy, "R8 busy until done", busy, 1);
    end
    chk(done && !busy, "R8 done ends busy", {done, busy}, 2'b10);
    chk(expQ.size() == 0 && txSeen == 36, "R2/R5 all 36 requests", txSeen, 36);
    chk(readCnt == 12, "R4 one read per pattern", readCnt, 12);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !fail && !memReq, "R9 reset outputs", {busy, done, fail, memReq}, 0);
    chk(failIdx == 0 && failExp == 0 && failObs == 0, "R9 reset capture", failObs, 0);
    rstN = 1'b1;
    @(negedge clk);

    // clean run, with a start pulse mid-run that must be ignored (R8)
    runSeq(16'h0100, 1'b1);
    chk(!fail, "R5 clean run passes", fail, 0);

    // two flips: first at pattern 3, second at 7 (R5, R6)
    flipA = 3; flipB = 7;
    runSeq(16'h2222, 1'b0);
    chk(fail, "R5 mismatch sets fail", fail, 1);
    chk(failIdx == 4'd3, "R6 first failing index", failIdx, 3);
    chk(failExp == expPat[3], "R6 expected word", failExp, expPat[3]);
    chk(failObs == (expPat[3] ^ flipMask), "R6 observed word", failObs, expPat[3] ^ flipMask);

    // R7 stickiness while idle
    repeat (20) @(negedge clk);
    chk(done && fail && failIdx == 4'd3, "R7 sticky done/fail", {done, fail}, 2'b11);

    // floating byte lane 2 (R10)
    flipA = -1; flipB = -1; faultLane = 2;
    runSeq(16'hFFF0, 1'b0);
    chk(fail && failIdx == 4'd0, "R10 lane fault caught at pattern 0", failIdx, 0);
    chk(failObs == 64'hAAAAAAAAAAABAAAA, "R10 observed shows disturb byte", failObs, 64'hAAAAAAAAAAABAAAA);
    chk(failExp == expPat[0], "R10 expected word", failExp, expPat[0]);

    // clean again: start clears previous failure (R7)
    faultLane = -1;
    runSeq(16'h0042, 1'b0);
    chk(!fail && failObs == 0, "R7 fresh run clears failure", {fail, failObs}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule